// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the bus-facing side of an asynchronous serial port. A word-aligned register bus with single-cycle read and write strobes reaches sixteen registers. Among them are configuration bytes for the line format, baud divisor, port control and flow control. A data register writes into a 16-entry transmit queue and reads from a 16-entry receive queue. Further registers report modem and queue flags, per-character receive errors, and pending interrupt causes.

The shift logic and the baud generator sit outside the block. The transmitter takes characters from the head of the transmit queue with a pop strobe. The receiver pushes characters, together with their error bits, into the receive queue. A separate input tells the block that the line is busy, and another pulses when a receive timeout occurs. Four interrupt causes are latched and masked by enable bits in the control register, then merged into a single request line.

Top module: `serial_regif`

## Requirements
- R1: After reset all configuration registers read 0, the identification register reads 0x4 (only transmit pending, because the queue is empty and the threshold is 0), and the interrupt line is low.
- R2: The configuration registers at word indices 2, 3, 4, 5 and 8 to 15 store the low byte of a write and read it back zero-extended. The divisor output is {index 3, index 4}. Index 2 drives the line output, index 5 drives the control output, and index 9 drives the flow output.
- R3: A write to index 0 appends its low byte to the transmit queue, and a write to a full queue is dropped. The transmit head and its valid flag are outputs, and the pop strobe advances the head in write order.
- R4: A read of index 0 returns the oldest received byte and removes it. A read while the receive queue is empty returns 0 and changes nothing.
- R5: The flag register (index 6) reads CTS at bit 0, DSR at bit 1, DCD at bit 2, line busy at bit 3, receive empty at bit 4, transmit full at bit 5, receive full at bit 6 and transmit empty at bit 7. Writes to it have no effect.
- R6: The status register (index 1) holds framing at bit 0, parity at bit 1 and break at bit 2 for the character most recently read from index 0; the receive error input supplies them as {break, parity, framing}. A push into a full receive queue drops the character and sets bit 3. Any write to index 1 clears all four bits.
- R7: Receive pending (identification bit 1) is set while the receive count is nonzero and at least the value at index 14. Transmit pending (bit 2) is set while the transmit count is at most the value at index 15.
- R8: Modem pending (bit 0) is set by either edge of CTS, and timeout pending (bit 3) is set by the receive timeout pulse.
- R9: Any write to the identification register (index 7) clears all pending bits. A cause whose condition still holds sets its bit again.
- R10: The interrupt line is the OR of each pending bit ANDed with its enable in the control register: modem at bit 3, receive at bit 4, transmit at bit 5 and timeout at bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busWrite | input | 1 | Single-cycle write strobe |
| busRead | input | 1 | Single-cycle read strobe |
| busAddr | input | 6 | Byte address; bits 5:2 select the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register |
| txPop | input | 1 | Transmitter takes the head character |
| txData | output | 8 | Head of the transmit queue |
| txValid | output | 1 | Transmit queue holds a character |
| rxPush | input | 1 | Receiver delivers a character |
| rxData | input | 8 | Received character |
| rxErr | input | 3 | {break, parity, framing} of the character |
| rxTimeout | input | 1 | Receive timeout pulse |
| lineBusy | input | 1 | Transmitter still shifting |
| ctsIn | input | 1 | Clear-to-send level |
| dsrIn | input | 1 | Data-set-ready level |
| dcdIn | input | 1 | Carrier-detect level |
| cfgLine | output | 8 | Line format byte |
| cfgCtrl | output | 8 | Control byte |
| cfgDivisor | output | 16 | Baud divisor |
| cfgRts | output | 8 | Flow control byte |
| irq | output | 1 | Interrupt request |

## Verification
The checker covers the properties that hold on every cycle. A full transmit queue never grows. An empty receive queue stays empty when nothing is pushed. A push into a full receive queue raises the overrun bit. Each CTS edge and each timeout pulse leaves its pending bit set, and the request line stays low whenever all enables are clear. The directed scenarios cover what needs a history of bus traffic: queue ordering, dropped writes, latching and clearing of error status, the two threshold comparisons, clearing of the identification register with level causes setting again, and the masking of each cause.

// File: rtl/serial_regif_pkg.sv
package serial_regif_pkg;
  localparam int REG_COUNT = 16;
  localparam int IDX_W     = $clog2(REG_COUNT);
  localparam int ADDR_W    = IDX_W + 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_DATA     = 4'd0,
    IDX_RXSTAT   = 4'd1,
    IDX_LINE     = 4'd2,
    IDX_DIVHI    = 4'd3,
    IDX_DIVLO    = 4'd4,
    IDX_CTRL     = 4'd5,
    IDX_FLAGS    = 4'd6,
    IDX_IDENT    = 4'd7,
    IDX_IRLP     = 4'd8,
    IDX_RTSCTL   = 4'd9,
    IDX_RTSLEAD  = 4'd10,
    IDX_RTSTRAIL = 4'd11,
    IDX_DRVEN    = 4'd12,
    IDX_BAUDMODE = 4'd13,
    IDX_RXTHR    = 4'd14,
    IDX_TXTHR    = 4'd15
  } regIdx_e;

  // storage present for line, divisor, control and indices 8..15
  localparam logic [REG_COUNT-1:0] CFG_MASK = 16'hFF3C;

  typedef struct packed {
    logic             txPush;
    logic             rxPop;
    logic             statClr;
    logic             identClr;
    logic             cfgWrite;
    logic [IDX_W-1:0] idx;
  } busStrobe_t;
endpackage

// File: rtl/serial_regif_ctrl.sv
module serial_regif_ctrl
  import serial_regif_pkg::*;
(
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  logic [IDX_W-1:0] idx;
  logic [1:0]       unusedByteSel;

  assign idx           = busAddr[ADDR_W-1:2];
  assign unusedByteSel = busAddr[1:0];

  always_comb begin
    strobe     = '0;
    strobe.idx = idx;
    if (busWrite) begin
      case (idx)
        IDX_DATA:   strobe.txPush   = 1'b1;
        IDX_RXSTAT: strobe.statClr  = 1'b1;
        IDX_IDENT:  strobe.identClr = 1'b1;
        default:    strobe.cfgWrite = CFG_MASK[idx];
      endcase
    end
    if (busRead && idx == IDX_DATA) strobe.rxPop = 1'b1;
  end
endmodule

// File: rtl/serial_regif_fifo.sv
module serial_regif_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = count == CNT_W'(DEPTH);
  assign empty  = count == '0;
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end
endmodule

// File: rtl/serial_regif_data.sv
module serial_regif_data
  import serial_regif_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int BUS_W      = 32,
  parameter int ERR_W      = 3,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  input  logic                txPop,
  output logic [DATA_W-1:0]   txData,
  output logic                txValid,
  input  logic                rxPush,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [ERR_W-1:0]    rxErr,
  input  logic                rxTimeout,
  input  logic                lineBusy,
  input  logic                ctsIn,
  input  logic                dsrIn,
  input  logic                dcdIn,
  output logic [DATA_W-1:0]   cfgLine,
  output logic [DATA_W-1:0]   cfgCtrl,
  output logic [2*DATA_W-1:0] cfgDivisor,
  output logic [DATA_W-1:0]   cfgRts,
  output logic                irq,
  output logic [3:0]          pendVec,
  output logic [3:0]          rxStat,
  output logic [CNT_W-1:0]    txCount,
  output logic [CNT_W-1:0]    rxCount
);
  localparam int RXE_W = DATA_W + ERR_W;

  logic [DATA_W-1:0] cfgMem [REG_COUNT];
  logic [RXE_W-1:0]  rxHead;
  logic              txFull, txEmpty, rxFull, rxEmpty;
  logic              ctsPrev;
  logic [3:0]        setVec;
  logic [DATA_W-1:0] flagByte, rdByte;
  logic [BUS_W-DATA_W-1:0] unusedHighData;

  assign unusedHighData = busWdata[BUS_W-1:DATA_W];

  // configuration bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) cfgMem[i] <= '0;
    end else if (strobe.cfgWrite) begin
      cfgMem[strobe.idx] <= busWdata[DATA_W-1:0];
    end
  end

  assign cfgLine    = cfgMem[IDX_LINE];
  assign cfgCtrl    = cfgMem[IDX_CTRL];
  assign cfgDivisor = {cfgMem[IDX_DIVHI], cfgMem[IDX_DIVLO]};
  assign cfgRts     = cfgMem[IDX_RTSCTL];

  serial_regif_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(strobe.txPush), .pushData(busWdata[DATA_W-1:0]),
    .pop(txPop), .head(txData), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  serial_regif_fifo #(.WIDTH(RXE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(rxPush), .pushData({rxErr, rxData}),
    .pop(strobe.rxPop), .head(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assign txValid = !txEmpty;

  // receive status: error bits follow the character last popped; overrun sticky
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStat <= '0;
    end else begin
      if (strobe.statClr) rxStat <= '0;
      if (strobe.rxPop && !rxEmpty) rxStat[ERR_W-1:0] <= rxHead[RXE_W-1:DATA_W];
      if (rxPush && rxFull) rxStat[3] <= 1'b1;
    end
  end

  // interrupt causes: {timeout, transmit, receive, modem}
  assign setVec[0] = ctsIn != ctsPrev;
  assign setVec[1] = (rxCount != '0) && (DATA_W'(rxCount) >= cfgMem[IDX_RXTHR]);
  assign setVec[2] = DATA_W'(txCount) <= cfgMem[IDX_TXTHR];
  assign setVec[3] = rxTimeout;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsPrev <= ctsIn;
      pendVec <= '0;
    end else begin
      ctsPrev <= ctsIn;
      pendVec <= (strobe.identClr ? 4'b0 : pendVec) | setVec;
    end
  end

  assign irq = |(pendVec & cfgMem[IDX_CTRL][6:3]);

  assign flagByte = DATA_W'({txEmpty, rxFull, txFull, rxEmpty, lineBusy, dcdIn, dsrIn, ctsIn});

  always_comb begin
    case (strobe.idx)
      IDX_DATA:   rdByte = rxEmpty ? '0 : rxHead[DATA_W-1:0];
      IDX_RXSTAT: rdByte = DATA_W'(rxStat);
      IDX_FLAGS:  rdByte = flagByte;
      IDX_IDENT:  rdByte = DATA_W'(pendVec);
      default:    rdByte = cfgMem[strobe.idx];
    endcase
  end

  assign busRdata = BUS_W'(rdByte);
endmodule

// File: rtl/serial_regif.sv
module serial_regif
  import serial_regif_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int BUS_W      = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrite,
  input  logic                busRead,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  input  logic                txPop,
  output logic [DATA_W-1:0]   txData,
  output logic                txValid,
  input  logic                rxPush,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [2:0]          rxErr,
  input  logic                rxTimeout,
  input  logic                lineBusy,
  input  logic                ctsIn,
  input  logic                dsrIn,
  input  logic                dcdIn,
  output logic [DATA_W-1:0]   cfgLine,
  output logic [DATA_W-1:0]   cfgCtrl,
  output logic [2*DATA_W-1:0] cfgDivisor,
  output logic [DATA_W-1:0]   cfgRts,
  output logic                irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  busStrobe_t       strobe;
  logic [3:0]       pendVec;
  logic [3:0]       rxStat;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;

  serial_regif_ctrl u_ctrl (
    .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr), .strobe(strobe)
  );

  serial_regif_data #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .BUS_W(BUS_W), .ERR_W(3)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .busRdata(busRdata),
    .txPop(txPop), .txData(txData), .txValid(txValid),
    .rxPush(rxPush), .rxData(rxData), .rxErr(rxErr), .rxTimeout(rxTimeout),
    .lineBusy(lineBusy), .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn),
    .cfgLine(cfgLine), .cfgCtrl(cfgCtrl), .cfgDivisor(cfgDivisor), .cfgRts(cfgRts),
    .irq(irq), .pendVec(pendVec), .rxStat(rxStat), .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/serial_regif_chk.sv
module serial_regif_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [5:0]        busAddr,
  input logic              txPop,
  input logic              rxPush,
  input logic              rxTimeout,
  input logic              ctsIn,
  input logic [DATA_W-1:0] cfgCtrl,
  input logic              irq,
  input logic [3:0]        pendVec,
  input logic [3:0]        rxStat,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount
);
  p_tx_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == CNT_W'(FIFO_DEPTH) && busWrite && busAddr[5:2] == 4'd0 && !txPop)
      |=> txCount == CNT_W'(FIFO_DEPTH));

  p_rx_empty_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0 && !rxPush) |=> rxCount == '0);

  p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxCount == CNT_W'(FIFO_DEPTH)) |=> rxStat[3]);

  p_cts_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctsIn != $past(ctsIn)) |=> pendVec[0]);

  p_timeout_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxTimeout |=> pendVec[3]);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCtrl[6:3] == 4'b0) |-> !irq);
endmodule

bind serial_regif serial_regif_chk #(.FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr), .txPop(txPop),
  .rxPush(rxPush), .rxTimeout(rxTimeout), .ctsIn(ctsIn), .cfgCtrl(cfgCtrl), .irq(irq),
  .pendVec(pendVec), .rxStat(rxStat), .txCount(txCount), .rxCount(rxCount)
);

// File: tb/serial_regif_tb.sv
module serial_regif_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic        txPop = 1'b0, txValid;
  logic [7:0]  txData;
  logic        rxPush = 1'b0;
  logic [7:0]  rxData = '0;
  logic [2:0]  rxErr = '0;
  logic        rxTimeout = 1'b0, lineBusy = 1'b0;
  logic        ctsIn = 1'b0, dsrIn = 1'b0, dcdIn = 1'b0;
  logic [7:0]  cfgLine, cfgCtrl, cfgRts;
  logic [15:0] cfgDivisor;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_regif u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txPop(txPop), .txData(txData), .txValid(txValid),
    .rxPush(rxPush), .rxData(rxData), .rxErr(rxErr), .rxTimeout(rxTimeout), .lineBusy(lineBusy),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn), .cfgLine(cfgLine), .cfgCtrl(cfgCtrl),
    .cfgDivisor(cfgDivisor), .cfgRts(cfgRts), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic regWr(input int idx, input logic [31:0] val);
    @(negedge clk);
    busWrite = 1'b1; busAddr = 6'(idx << 2); busWdata = val;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic regRd(input int idx, output logic [31:0] val);
    @(negedge clk);
    busRead = 1'b1; busAddr = 6'(idx << 2);
    #1 val = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk);
    rxPush = 1'b1; rxData = d; rxErr = e;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic popTx(output logic [7:0] d, output logic v);
    @(negedge clk);
    d = txData; v = txValid; txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic pulseTimeout();
    @(negedge clk);
    rxTimeout = 1'b1;
    @(negedge clk);
    rxTimeout = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    regRd(6, v);  chk("R1 flags after reset", v, 32'h90);
    regRd(7, v);  chk("R1 ident after reset", v, 32'h4);
    regRd(2, v);  chk("R1 line reg after reset", v, 32'h0);
    regRd(14, v); chk("R1 rx threshold after reset", v, 32'h0);
    chk("R1 irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    regWr(3, 32'h12); regWr(4, 32'hFFFF_FF34); regWr(2, 32'h7B); regWr(9, 32'h25);
    regWr(13, 32'hA5);
    chk("R2 divisor output", 32'(cfgDivisor), 32'h1234);
    chk("R2 line output", 32'(cfgLine), 32'h7B);
    chk("R2 flow output", 32'(cfgRts), 32'h25);
    regRd(13, v); chk("R2 readback index 13", v, 32'hA5);
    regRd(4, v);  chk("R2 readback low byte only", v, 32'h34);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    regWr(6, 32'hFF);
    regRd(6, v); chk("R5 flag write ignored", v, 32'h90);
    @(negedge clk); ctsIn = 1'b1; dcdIn = 1'b1; lineBusy = 1'b1;
    regRd(6, v); chk("R5 modem and busy bits", v, 32'h9D);
    @(negedge clk); ctsIn = 1'b0; dcdIn = 1'b0; lineBusy = 1'b0; dsrIn = 1'b1;
    regRd(6, v); chk("R5 dsr bit", v, 32'h92);
    @(negedge clk); dsrIn = 1'b0;
  endtask

  task automatic t_tx();
    logic [31:0] v; logic [7:0] d; logic ok;
    chk("R3 no head when empty", 32'(txValid), 32'h0);
    for (int i = 0; i < 17; i++) regWr(0, 32'h40 + 32'(i));
    regRd(6, v); chk("R5 R3 tx full flag", v, 32'h30);
    for (int i = 0; i < 16; i++) begin
      popTx(d, ok);
      chk("R3 tx order", {23'b0, ok, d}, {23'b0, 1'b1, 8'h40 + 8'(i)});
    end
    tick();
    chk("R3 seventeenth write dropped", 32'(txValid), 32'h0);
    regRd(6, v); chk("R5 tx empty again", v, 32'h90);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    pushRx(8'h5A, 3'b010); pushRx(8'hC3, 3'b000);
    regRd(0, v); chk("R4 first rx byte", v, 32'h5A);
    regRd(1, v); chk("R6 parity of first byte", v, 32'h2);
    regRd(0, v); chk("R4 second rx byte", v, 32'hC3);
    regRd(1, v); chk("R6 clean second byte", v, 32'h0);
    for (int i = 0; i < 17; i++) pushRx(8'h80 + 8'(i), (i == 3) ? 3'b101 : 3'b000);
    regRd(6, v); chk("R5 rx full flag", v, 32'hC0);
    regRd(1, v); chk("R6 overrun set", v, 32'h8);
    regWr(1, 32'h5);
    regRd(1, v); chk("R6 write clears status", v, 32'h0);
    for (int i = 0; i < 16; i++) begin
      regRd(0, v); chk("R4 rx drain order", v, 32'h80 + 32'(i));
      if (i == 3) begin
        regRd(1, v); chk("R6 break and framing latched", v, 32'h5);
      end
    end
    regRd(0, v); chk("R4 empty read returns 0", v, 32'h0);
    regRd(6, v); chk("R4 empty read changes nothing", v, 32'h90);
  endtask

  task automatic t_thresh();
    logic [31:0] v; logic [7:0] d; logic ok;
    regWr(14, 32'd3);
    pushRx(8'h01, 3'b0); pushRx(8'h02, 3'b0);
    regWr(7, 32'h0);
    regRd(7, v); chk("R7 rx below threshold", v & 32'h2, 32'h0);
    pushRx(8'h03, 3'b0); tick();
    regRd(7, v); chk("R7 rx at threshold", v & 32'h2, 32'h2);
    for (int i = 0; i < 3; i++) regRd(0, v);
    regWr(14, 32'd0);
    regWr(15, 32'd2);
    for (int i = 0; i < 3; i++) regWr(0, 32'h10 + 32'(i));
    regWr(7, 32'h0);
    regRd(7, v); chk("R7 tx above threshold", v & 32'h4, 32'h0);
    popTx(d, ok); tick();
    regRd(7, v); chk("R7 tx at threshold", v & 32'h4, 32'h4);
    popTx(d, ok); popTx(d, ok);
    regWr(15, 32'd0);
  endtask

  task automatic t_pending();
    logic [31:0] v; logic [7:0] d; logic ok;
    regWr(0, 32'h77);
    regWr(7, 32'h0);
    regRd(7, v); chk("R9 ident cleared", v, 32'h0);
    @(negedge clk); ctsIn = 1'b1; tick();
    regRd(7, v); chk("R8 cts rising sets modem", v, 32'h1);
    regWr(7, 32'h0);
    regRd(7, v); chk("R9 modem cleared", v, 32'h0);
    @(negedge clk); ctsIn = 1'b0; tick();
    regRd(7, v); chk("R8 cts falling sets modem", v, 32'h1);
    regWr(7, 32'h0);
    pulseTimeout();
    regRd(7, v); chk("R8 timeout pending", v, 32'h8);
    regWr(7, 32'h0);
    regRd(7, v); chk("R9 timeout cleared", v, 32'h0);
    popTx(d, ok); tick();
    regRd(7, v); chk("R9 level cause sets again", v, 32'h4);
  endtask

  task automatic t_irq();
    logic [7:0] d; logic ok;
    regWr(0, 32'h99);
    regWr(7, 32'h0);
    regWr(5, 32'h78);
    chk("R2 control output", 32'(cfgCtrl), 32'h78);
    chk("R10 irq idle", 32'(irq), 32'h0);
    pulseTimeout();
    chk("R10 timeout raises irq", 32'(irq), 32'h1);
    regWr(7, 32'h0);
    chk("R10 irq drops after clear", 32'(irq), 32'h0);
    regWr(5, 32'h08);
    pulseTimeout();
    chk("R10 masked timeout", 32'(irq), 32'h0);
    @(negedge clk); ctsIn = 1'b1; tick();
    chk("R10 modem enabled raises irq", 32'(irq), 32'h1);
    regWr(5, 32'h0);
    chk("R10 all masked", 32'(irq), 32'h0);
    popTx(d, ok);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(); tick();
    t_reset();
    t_config();
    t_flags();
    t_tx();
    t_rx();
    t_thresh();
    t_pending();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule